// File: doc/BRIEF.md
# Gated Router Bypass Datapath

This block sits on the four directional ports of a mesh router that can be switched off. While the router is powered, it is a set of transparent steering muxes: incoming flits and downstream credit returns go into the router core, and the core's outgoing flits and freed-slot credits go out on the links. When the gate select is raised, the core is cut out. A flit that arrives on one side is held for exactly one cycle in a per-direction register and then leaves on the opposite side, carrying the virtual channel that the upstream router already chose. Credit returns from the far side are passed straight back the way the flits came. The routers on either side then act as direct neighbours for flow control.

The block also runs the credit handover at the two power-state edges. On the first gated cycle it tells each upstream router to drop its count for this port and to load the counts that the core held for the opposite output. On the first powered cycle it tells each upstream router that the core's empty input buffer is fully free. Parameters disable the pass-through on an axis that lacks a neighbour on both sides, for edge and corner routers. A single flag reports when every pass-through register is empty, so the power controller can tell when output draining has finished.

Top module: `gated_router_bypass`

## Requirements
- R1: With `bypassSel` at 0, `linkIn*[d]` appears on `coreIn*[d]` and `credIn*[d]` appears on `coreCredIn*[d]` in the same cycle. `coreOut*[d]` drives `linkOut*[d]` and `coreCredRet*[d]` drives `credOut*[d]` in the same cycle. Ports are indexed 0 = north, 1 = east, 2 = south, 3 = west.
- R2: With `bypassSel` at 1 on an enabled axis, a flit accepted on `linkIn[d]` leaves on `linkOut[d^2]` exactly one cycle later, with the same VC id and the same data. `coreInValid` stays 0 for the whole time the router is gated, and so does `coreCredInValid`.
- R3: `latchEmpty` is 1 when no pass-through register holds a flit. It goes low in the cycle after a gated flit is accepted and returns high once the last flit has left. It is 1 out of reset and in the first powered cycle after a wake.
- R4: While gated, a credit on `credIn[d^2]` appears on `credOut[d]` in the same cycle with an unchanged VC id, and nothing reaches the core's credit input.
- R5: In the first cycle in which `bypassSel` is 1 after being 0, `upLoadValid[d]` pulses for one cycle on every enabled port, with `upLoadCnt[d][v]` equal to `coreCredCnt[d^2][v]`. The upstream counter applies the load first and then any relayed credit in the same cycle.
- R6: In the first cycle in which `bypassSel` is 0 after being 1, `upFullValid[d]` pulses for one cycle on every enabled port. This tells the upstream counter to set every VC to the input buffer depth.
- R7: With `Y_PASS` = 0, ports 0 and 2 forward no flits, relay no credits and raise neither handover strobe while gated. `X_PASS` = 0 does the same for ports 1 and 3.
- R8: An upstream counter that follows only this block's outputs always holds the free slots of the buffer that currently sits downstream of it. That buffer is the core's input buffer while the router is powered and the far router's buffer while it is gated, and the counter stays correct across both a sleep and a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bypassSel | input | 1 | 0 = core in path, 1 = gated pass-through |
| linkInValid | input | 4 | Flit valid from each neighbour |
| linkInVc | input | 4 x VC_W | VC id of each incoming flit |
| linkInData | input | 4 x FLIT_W | Payload of each incoming flit |
| linkOutValid | output | 4 | Flit valid toward each neighbour |
| linkOutVc | output | 4 x VC_W | VC id of each outgoing flit |
| linkOutData | output | 4 x FLIT_W | Payload of each outgoing flit |
| coreInValid | output | 4 | Flit valid into the core input buffers |
| coreInVc | output | 4 x VC_W | VC id toward the core |
| coreInData | output | 4 x FLIT_W | Payload toward the core |
| coreOutValid | input | 4 | Flit valid from the core crossbar |
| coreOutVc | input | 4 x VC_W | VC id from the core |
| coreOutData | input | 4 x FLIT_W | Payload from the core |
| credInValid | input | 4 | Credit return from each downstream neighbour |
| credInVc | input | 4 x VC_W | VC of each credit return |
| credOutValid | output | 4 | Credit return toward each upstream neighbour |
| credOutVc | output | 4 x VC_W | VC of each credit sent upstream |
| coreCredRetValid | input | 4 | Core freed a slot of an input buffer |
| coreCredRetVc | input | 4 x VC_W | VC of the freed slot |
| coreCredInValid | output | 4 | Downstream credit delivered to the core counters |
| coreCredInVc | output | 4 x VC_W | VC of that credit |
| coreCredCnt | input | 4 x NUM_VC x CNT_W | Core's present credit count per output port and VC |
| upLoadValid | output | 4 | Upstream: clear and load the counters for this port |
| upLoadCnt | output | 4 x NUM_VC x CNT_W | Counts to load, per VC |
| upFullValid | output | 4 | Upstream: set this port's counters to full |
| latchEmpty | output | 1 | No pass-through register holds a flit |

## Verification
A pass-through register that loses its valid bit, or that steers the wrong way, shows up one cycle after the flit enters. The flit is then missing, late, or on the wrong side. An edge detector that misses or repeats a transition shows up in the same cycle as a missing or doubled load or full pulse. A swapped source port for the copied counts, or a relayed credit lost at the sleep edge, shows up later. It appears as an upstream counter model that no longer equals the far buffer's free slots, and the bench compares the two right after the sleep edge, during streaming and at the wake edge.

// File: rtl/grb_pkg.sv
package grb_pkg;

  typedef enum logic [1:0] {DIR_N, DIR_E, DIR_S, DIR_W} dir_e;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic bypassOn;    // core cut out, pass-through active
    logic enterSleep;  // first gated cycle
    logic leaveSleep;  // first powered cycle
  } gate_strobe_t;

  function automatic int oppositeOf(input int d);
    return d ^ 2;
  endfunction

  function automatic bit isVertical(input int d);
    return (d == int'(DIR_N)) || (d == int'(DIR_S));
  endfunction

endpackage

// File: rtl/grb_ctrl.sv
module grb_ctrl
  import grb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bypassSel,
  output gate_strobe_t strobe
);

  logic selPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= 1'b0;
    else       selPrev <= bypassSel;
  end

  always_comb begin
    strobe.bypassOn   = bypassSel;
    strobe.enterSleep = bypassSel & ~selPrev;
    strobe.leaveSleep = ~bypassSel & selPrev;
  end

endmodule

// File: rtl/grb_datapath.sv
module grb_datapath
  import grb_pkg::*;
#(
  parameter int FLIT_W    = 128,
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 6,
  parameter bit X_PASS    = 1'b1,
  parameter bit Y_PASS    = 1'b1,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1),
  localparam int PORTS    = 4
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  gate_strobe_t                             strobe,
  input  logic [PORTS-1:0]                         linkInValid,
  input  logic [PORTS-1:0][VC_W-1:0]               linkInVc,
  input  logic [PORTS-1:0][FLIT_W-1:0]             linkInData,
  output logic [PORTS-1:0]                         linkOutValid,
  output logic [PORTS-1:0][VC_W-1:0]               linkOutVc,
  output logic [PORTS-1:0][FLIT_W-1:0]             linkOutData,
  output logic [PORTS-1:0]                         coreInValid,
  output logic [PORTS-1:0][VC_W-1:0]               coreInVc,
  output logic [PORTS-1:0][FLIT_W-1:0]             coreInData,
  input  logic [PORTS-1:0]                         coreOutValid,
  input  logic [PORTS-1:0][VC_W-1:0]               coreOutVc,
  input  logic [PORTS-1:0][FLIT_W-1:0]             coreOutData,
  input  logic [PORTS-1:0]                         credInValid,
  input  logic [PORTS-1:0][VC_W-1:0]               credInVc,
  output logic [PORTS-1:0]                         credOutValid,
  output logic [PORTS-1:0][VC_W-1:0]               credOutVc,
  input  logic [PORTS-1:0]                         coreCredRetValid,
  input  logic [PORTS-1:0][VC_W-1:0]               coreCredRetVc,
  output logic [PORTS-1:0]                         coreCredInValid,
  output logic [PORTS-1:0][VC_W-1:0]               coreCredInVc,
  input  logic [PORTS-1:0][NUM_VC-1:0][CNT_W-1:0]  coreCredCnt,
  output logic [PORTS-1:0]                         upLoadValid,
  output logic [PORTS-1:0][NUM_VC-1:0][CNT_W-1:0]  upLoadCnt,
  output logic [PORTS-1:0]                         upFullValid,
  output logic [PORTS-1:0]                         latchValid
);

  for (genvar d = 0; d < PORTS; d++) begin : g_port
    localparam int SRC = oppositeOf(d);               // side feeding output d
    localparam bit AX  = isVertical(d) ? Y_PASS : X_PASS;

    // Powered path: links and credits into the core
    assign coreInValid[d]     = ~strobe.bypassOn & linkInValid[d];
    assign coreInVc[d]        = linkInVc[d];
    assign coreInData[d]      = linkInData[d];
    assign coreCredInValid[d] = ~strobe.bypassOn & credInValid[d];
    assign coreCredInVc[d]    = credInVc[d];

    if (AX) begin : g_pass
      logic              holdValid;
      logic [VC_W-1:0]   holdVc;
      logic [FLIT_W-1:0] holdData;
      logic              capture;

      assign capture = strobe.bypassOn & linkInValid[SRC];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) holdValid <= 1'b0;
        else       holdValid <= capture;
      end

      always_ff @(posedge clk) begin
        if (capture) begin
          holdVc   <= linkInVc[SRC];
          holdData <= linkInData[SRC];
        end
      end

      assign latchValid[d]   = holdValid;
      assign linkOutValid[d] = strobe.bypassOn ? holdValid : coreOutValid[d];
      assign linkOutVc[d]    = strobe.bypassOn ? holdVc    : coreOutVc[d];
      assign linkOutData[d]  = strobe.bypassOn ? holdData  : coreOutData[d];

      // Credits for input d come back on output side SRC while gated
      assign credOutValid[d] = strobe.bypassOn ? credInValid[SRC] : coreCredRetValid[d];
      assign credOutVc[d]    = strobe.bypassOn ? credInVc[SRC]    : coreCredRetVc[d];

      assign upLoadValid[d]  = strobe.enterSleep;
      assign upLoadCnt[d]    = coreCredCnt[SRC];
      assign upFullValid[d]  = strobe.leaveSleep;
    end else begin : g_stop
      assign latchValid[d]   = 1'b0;
      assign linkOutValid[d] = ~strobe.bypassOn & coreOutValid[d];
      assign linkOutVc[d]    = coreOutVc[d];
      assign linkOutData[d]  = coreOutData[d];
      assign credOutValid[d] = ~strobe.bypassOn & coreCredRetValid[d];
      assign credOutVc[d]    = coreCredRetVc[d];
      assign upLoadValid[d]  = 1'b0;
      assign upLoadCnt[d]    = '0;
      assign upFullValid[d]  = 1'b0;
    end
  end

endmodule

// File: rtl/gated_router_bypass.sv
module gated_router_bypass
  import grb_pkg::*;
#(
  parameter int FLIT_W    = 128,
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 6,
  parameter bit X_PASS    = 1'b1,
  parameter bit Y_PASS    = 1'b1,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              bypassSel,
  input  logic [3:0]                        linkInValid,
  input  logic [3:0][VC_W-1:0]              linkInVc,
  input  logic [3:0][FLIT_W-1:0]            linkInData,
  output logic [3:0]                        linkOutValid,
  output logic [3:0][VC_W-1:0]              linkOutVc,
  output logic [3:0][FLIT_W-1:0]            linkOutData,
  output logic [3:0]                        coreInValid,
  output logic [3:0][VC_W-1:0]              coreInVc,
  output logic [3:0][FLIT_W-1:0]            coreInData,
  input  logic [3:0]                        coreOutValid,
  input  logic [3:0][VC_W-1:0]              coreOutVc,
  input  logic [3:0][FLIT_W-1:0]            coreOutData,
  input  logic [3:0]                        credInValid,
  input  logic [3:0][VC_W-1:0]              credInVc,
  output logic [3:0]                        credOutValid,
  output logic [3:0][VC_W-1:0]              credOutVc,
  input  logic [3:0]                        coreCredRetValid,
  input  logic [3:0][VC_W-1:0]              coreCredRetVc,
  output logic [3:0]                        coreCredInValid,
  output logic [3:0][VC_W-1:0]              coreCredInVc,
  input  logic [3:0][NUM_VC-1:0][CNT_W-1:0] coreCredCnt,
  output logic [3:0]                        upLoadValid,
  output logic [3:0][NUM_VC-1:0][CNT_W-1:0] upLoadCnt,
  output logic [3:0]                        upFullValid,
  output logic                              latchEmpty
);

  gate_strobe_t strobe;
  logic [3:0]   latchValid;

  grb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bypassSel (bypassSel),
    .strobe    (strobe)
  );

  grb_datapath #(
    .FLIT_W    (FLIT_W),
    .NUM_VC    (NUM_VC),
    .BUF_DEPTH (BUF_DEPTH),
    .X_PASS    (X_PASS),
    .Y_PASS    (Y_PASS)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .linkInValid      (linkInValid),
    .linkInVc         (linkInVc),
    .linkInData       (linkInData),
    .linkOutValid     (linkOutValid),
    .linkOutVc        (linkOutVc),
    .linkOutData      (linkOutData),
    .coreInValid      (coreInValid),
    .coreInVc         (coreInVc),
    .coreInData       (coreInData),
    .coreOutValid     (coreOutValid),
    .coreOutVc        (coreOutVc),
    .coreOutData      (coreOutData),
    .credInValid      (credInValid),
    .credInVc         (credInVc),
    .credOutValid     (credOutValid),
    .credOutVc        (credOutVc),
    .coreCredRetValid (coreCredRetValid),
    .coreCredRetVc    (coreCredRetVc),
    .coreCredInValid  (coreCredInValid),
    .coreCredInVc     (coreCredInVc),
    .coreCredCnt      (coreCredCnt),
    .upLoadValid      (upLoadValid),
    .upLoadCnt        (upLoadCnt),
    .upFullValid      (upFullValid),
    .latchValid       (latchValid)
  );

  assign latchEmpty = ~|latchValid;

endmodule

// File: rtl/grb_bypass_chk.sv
module grb_bypass_chk #(
  parameter int FLIT_W    = 128,
  parameter int NUM_VC    = 4,
  parameter int BUF_DEPTH = 6,
  parameter bit X_PASS    = 1'b1,
  parameter bit Y_PASS    = 1'b1,
  localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              bypassSel,
  input logic [3:0]                        linkInValid,
  input logic [3:0][VC_W-1:0]              linkInVc,
  input logic [3:0][FLIT_W-1:0]            linkInData,
  input logic [3:0]                        linkOutValid,
  input logic [3:0][VC_W-1:0]              linkOutVc,
  input logic [3:0][FLIT_W-1:0]            linkOutData,
  input logic [3:0]                        coreInValid,
  input logic [3:0]                        coreOutValid,
  input logic [3:0][FLIT_W-1:0]            coreOutData,
  input logic [3:0]                        credInValid,
  input logic [3:0][VC_W-1:0]              credInVc,
  input logic [3:0]                        credOutValid,
  input logic [3:0][VC_W-1:0]              credOutVc,
  input logic [3:0]                        coreCredInValid,
  input logic [3:0][NUM_VC-1:0][CNT_W-1:0] coreCredCnt,
  input logic [3:0]                        upLoadValid,
  input logic [3:0][NUM_VC-1:0][CNT_W-1:0] upLoadCnt,
  input logic [3:0]                        upFullValid,
  input logic                              latchEmpty
);

  for (genvar d = 0; d < 4; d++) begin : g_chk
    localparam int SRC = d ^ 2;
    localparam bit AX  = (d == 0 || d == 2) ? Y_PASS : X_PASS;

    // R1: powered router hands core flits to the link unchanged
    p_core_to_link_r1: assert property (@(posedge clk) disable iff (!rstN)
      (!bypassSel && coreOutValid[d]) |-> (linkOutValid[d] && linkOutData[d] == coreOutData[d]));

    // R2: gated router keeps the core input quiet
    p_core_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
      bypassSel |-> (!coreInValid[d] && !coreCredInValid[d]));

    if (AX) begin : g_on
      // R2: one-cycle pass to the opposite side, VC and data kept
      p_pass_flit_r2: assert property (@(posedge clk) disable iff (!rstN)
        (bypassSel && linkInValid[SRC]) |=>
          (!bypassSel || (linkOutValid[d] && linkOutVc[d] == $past(linkInVc[SRC])
                          && linkOutData[d] == $past(linkInData[SRC]))));

      // R4: same-cycle credit relay
      p_relay_credit_r4: assert property (@(posedge clk) disable iff (!rstN)
        (bypassSel && credInValid[SRC]) |-> (credOutValid[d] && credOutVc[d] == credInVc[SRC]));

      // R5: load on sleep entry with opposite-port counts
      p_load_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $rose(bypassSel)) |-> (upLoadValid[d] && upLoadCnt[d] == coreCredCnt[SRC]));

      // R6: full on wake
      p_full_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $fell(bypassSel)) |-> upFullValid[d]);
    end else begin : g_off
      // R7: disabled axis stays silent while gated
      p_edge_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
        bypassSel |-> (!linkOutValid[d] && !credOutValid[d] && !upLoadValid[d] && !upFullValid[d]));
    end

    // R5: load strobe lasts a single cycle
    p_load_single_r5: assert property (@(posedge clk) disable iff (!rstN)
      upLoadValid[d] |=> !upLoadValid[d]);

    // R6: full strobe lasts a single cycle
    p_full_single_r6: assert property (@(posedge clk) disable iff (!rstN)
      upFullValid[d] |=> !upFullValid[d]);
  end

  // R3: nothing held in a register when the core is switched back in
  p_wake_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(bypassSel)) |-> latchEmpty);

endmodule

bind gated_router_bypass grb_bypass_chk #(
  .FLIT_W    (FLIT_W),
  .NUM_VC    (NUM_VC),
  .BUF_DEPTH (BUF_DEPTH),
  .X_PASS    (X_PASS),
  .Y_PASS    (Y_PASS)
) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .bypassSel       (bypassSel),
  .linkInValid     (linkInValid),
  .linkInVc        (linkInVc),
  .linkInData      (linkInData),
  .linkOutValid    (linkOutValid),
  .linkOutVc       (linkOutVc),
  .linkOutData     (linkOutData),
  .coreInValid     (coreInValid),
  .coreOutValid    (coreOutValid),
  .coreOutData     (coreOutData),
  .credInValid     (credInValid),
  .credInVc        (credInVc),
  .credOutValid    (credOutValid),
  .credOutVc       (credOutVc),
  .coreCredInValid (coreCredInValid),
  .coreCredCnt     (coreCredCnt),
  .upLoadValid     (upLoadValid),
  .upLoadCnt       (upLoadCnt),
  .upFullValid     (upFullValid),
  .latchEmpty      (latchEmpty)
);

// File: tb/gated_router_bypass_tb.sv
module gated_router_bypass_tb;

  localparam int FW    = 128;
  localparam int NVC   = 4;
  localparam int DEPTH = 6;
  localparam int VCW   = 2;
  localparam int CW    = 3;

  logic clk = 1'b0;
  logic rstN;
  logic bypassSel;
  logic [3:0]               linkInValid, linkOutValid, coreInValid, coreOutValid;
  logic [3:0][VCW-1:0]      linkInVc, linkOutVc, coreInVc, coreOutVc;
  logic [3:0][FW-1:0]       linkInData, linkOutData, coreInData, coreOutData;
  logic [3:0]               credInValid, credOutValid, coreCredRetValid, coreCredInValid;
  logic [3:0][VCW-1:0]      credInVc, credOutVc, coreCredRetVc, coreCredInVc;
  logic [3:0][NVC-1:0][CW-1:0] coreCredCnt, upLoadCnt, eUpLoadCnt;
  logic [3:0]               upLoadValid, upFullValid;
  logic                     latchEmpty;
  // edge-router copy (vertical axis without pass-through)
  logic [3:0]               eLinkOutValid, eCoreInValid, eCredOutValid, eCoreCredInValid;
  logic [3:0][VCW-1:0]      eLinkOutVc, eCoreInVc, eCredOutVc, eCoreCredInVc;
  logic [3:0][FW-1:0]       eLinkOutData, eCoreInData;
  logic [3:0]               eUpLoadValid, eUpFullValid;
  logic                     eLatchEmpty;

  always #5 clk = ~clk;

  gated_router_bypass #(.FLIT_W(FW), .NUM_VC(NVC), .BUF_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .bypassSel(bypassSel),
    .linkInValid(linkInValid), .linkInVc(linkInVc), .linkInData(linkInData),
    .linkOutValid(linkOutValid), .linkOutVc(linkOutVc), .linkOutData(linkOutData),
    .coreInValid(coreInValid), .coreInVc(coreInVc), .coreInData(coreInData),
    .coreOutValid(coreOutValid), .coreOutVc(coreOutVc), .coreOutData(coreOutData),
    .credInValid(credInValid), .credInVc(credInVc),
    .credOutValid(credOutValid), .credOutVc(credOutVc),
    .coreCredRetValid(coreCredRetValid), .coreCredRetVc(coreCredRetVc),
    .coreCredInValid(coreCredInValid), .coreCredInVc(coreCredInVc),
    .coreCredCnt(coreCredCnt), .upLoadValid(upLoadValid), .upLoadCnt(upLoadCnt),
    .upFullValid(upFullValid), .latchEmpty(latchEmpty));

  gated_router_bypass #(.FLIT_W(FW), .NUM_VC(NVC), .BUF_DEPTH(DEPTH), .X_PASS(1'b1), .Y_PASS(1'b0)) u_edge (
    .clk(clk), .rstN(rstN), .bypassSel(bypassSel),
    .linkInValid(linkInValid), .linkInVc(linkInVc), .linkInData(linkInData),
    .linkOutValid(eLinkOutValid), .linkOutVc(eLinkOutVc), .linkOutData(eLinkOutData),
    .coreInValid(eCoreInValid), .coreInVc(eCoreInVc), .coreInData(eCoreInData),
    .coreOutValid(coreOutValid), .coreOutVc(coreOutVc), .coreOutData(coreOutData),
    .credInValid(credInValid), .credInVc(credInVc),
    .credOutValid(eCredOutValid), .credOutVc(eCredOutVc),
    .coreCredRetValid(coreCredRetValid), .coreCredRetVc(coreCredRetVc),
    .coreCredInValid(eCoreCredInValid), .coreCredInVc(eCoreCredInVc),
    .coreCredCnt(coreCredCnt), .upLoadValid(eUpLoadValid), .upLoadCnt(eUpLoadCnt),
    .upFullValid(eUpFullValid), .latchEmpty(eLatchEmpty));

  typedef struct {
    logic [VCW-1:0] vc;
    logic [FW-1:0]  data;
    int             due;
  } item_t;

  item_t expQ[4][$];
  int cycle = 0;
  int checks = 0;
  int errors = 0;
  int upCnt[NVC];    // west upstream router's view of port 3
  int coreOcc[NVC];  // core input buffer occupancy on port 3
  int farOcc[NVC];   // east neighbour buffer occupancy

  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] pat(input int k);
    return {4{32'hA5C30000 + 32'(k * 17)}};
  endfunction

  // Monitor: scoreboard of link outputs and the upstream credit model
  always @(negedge clk) begin
    if (rstN) begin
      for (int p = 0; p < 4; p++) begin
        if (linkOutValid[p]) begin
          if (expQ[p].size() == 0) begin
            chk(1'b0, "R2 unexpected flit", {126'd0, 2'(p)}, 0);
          end else begin
            item_t it;
            it = expQ[p].pop_front();
            chk(linkOutVc[p] == it.vc && linkOutData[p] == it.data && cycle == it.due,
                "R2 flit scoreboard", linkOutData[p], it.data);
          end
          if (p == 1) farOcc[linkOutVc[p]]++;
        end
      end
      if (upLoadValid[3]) for (int v = 0; v < NVC; v++) upCnt[v] = int'(upLoadCnt[3][v]);
      if (upFullValid[3]) for (int v = 0; v < NVC; v++) upCnt[v] = DEPTH;
      if (credOutValid[3]) upCnt[credOutVc[3]]++;
      if (coreCredInValid[1]) coreCredCnt[1][coreCredInVc[1]] = coreCredCnt[1][coreCredInVc[1]] + 1'b1;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
    linkInValid = '0; coreOutValid = '0; credInValid = '0; coreCredRetValid = '0;
  endtask

  task automatic chkCred(input bit gated, input string tag);
    for (int v = 0; v < NVC; v++) begin
      int exp;
      exp = gated ? DEPTH - farOcc[v] : DEPTH - coreOcc[v];
      chk(upCnt[v] == exp, tag, FW'(upCnt[v]), FW'(exp));
    end
  endtask

  task automatic sendIn(input int d, input int vc, input logic [FW-1:0] data);
    linkInValid[d] = 1'b1; linkInVc[d] = VCW'(vc); linkInData[d] = data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; bypassSel = 1'b0;
    linkInValid = '0; linkInVc = '0; linkInData = '0;
    coreOutValid = '0; coreOutVc = '0; coreOutData = '0;
    credInValid = '0; credInVc = '0; coreCredRetValid = '0; coreCredRetVc = '0;
    for (int p = 0; p < 4; p++) for (int v = 0; v < NVC; v++) coreCredCnt[p][v] = CW'(DEPTH);
    for (int v = 0; v < NVC; v++) begin upCnt[v] = DEPTH; coreOcc[v] = 0; farOcc[v] = 0; end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    #5;
    // Reset state
    chk(linkOutValid == 0 && credOutValid == 0, "R1 reset outputs idle", FW'(linkOutValid), 0);
    chk(latchEmpty == 1'b1, "R3 reset latchEmpty", FW'(latchEmpty), 1);
    chk(upLoadValid == 0 && upFullValid == 0, "R5 R6 no strobe after reset", FW'({upLoadValid, upFullValid}), 0);
    cyc();

    // R1: powered inbound flit into core
    sendIn(3, 1, pat(1)); upCnt[1]--; coreOcc[1]++;
    #5 chk(coreInValid[3] && coreInVc[3] == 1 && coreInData[3] == pat(1), "R1 link to core", coreInData[3], pat(1));
    cyc();
    coreCredRetValid[3] = 1'b1; coreCredRetVc[3] = 2'd1; coreOcc[1]--;
    #5 chk(credOutValid[3] && credOutVc[3] == 1, "R1 core credit upstream", FW'(credOutVc[3]), 1);
    cyc();
    // R1: core sends two flits east on vc2
    for (int i = 0; i < 2; i++) begin
      item_t it;
      coreOutValid[1] = 1'b1; coreOutVc[1] = 2'd2; coreOutData[1] = pat(2 + i);
      it.vc = 2'd2; it.data = pat(2 + i); it.due = cycle; expQ[1].push_back(it);
      coreCredCnt[1][2] = coreCredCnt[1][2] - 1'b1;
      #5; cyc();
    end
    credInValid[1] = 1'b1; credInVc[1] = 2'd2; farOcc[2]--;
    #5 chk(coreCredInValid[1] && coreCredInVc[1] == 2 && credOutValid[3] == 1'b0, "R1 downstream credit to core",
           FW'(coreCredInVc[1]), 2);
    chkCred(1'b0, "R8 powered counter");
    cyc();

    // Sleep entry with a same-cycle credit return on vc2
    bypassSel = 1'b1;
    credInValid[1] = 1'b1; credInVc[1] = 2'd2; farOcc[2]--;
    #5;
    chk(upLoadValid == 4'hF, "R5 load strobe on all ports", FW'(upLoadValid), 4'hF);
    chk(upLoadCnt[3][2] == 3'd5 && upLoadCnt[3][0] == 3'd6, "R5 copied counts", FW'(upLoadCnt[3]), 0);
    chk(upLoadCnt[1] == coreCredCnt[3], "R5 opposite port counts", FW'(upLoadCnt[1]), FW'(coreCredCnt[3]));
    chk(credOutValid[3] && credOutVc[3] == 2 && coreCredInValid == 0, "R4 relay at sleep edge", FW'(credOutVc[3]), 2);
    chk(eUpLoadValid == 4'b1010, "R7 edge load ports", FW'(eUpLoadValid), 4'b1010);
    chkCred(1'b1, "R8 counter after sleep entry");
    cyc();
    #5 chk(upLoadValid == 0, "R5 load pulse ends", FW'(upLoadValid), 0);
    cyc();

    // Stream three flits west-to-east, one north-to-south
    for (int i = 0; i < 3; i++) begin
      item_t it;
      int vc;
      vc = (i == 2) ? 3 : i;
      sendIn(3, vc, pat(10 + i)); upCnt[vc]--;
      it.vc = VCW'(vc); it.data = pat(10 + i); it.due = cycle + 1; expQ[1].push_back(it);
      if (i == 0) begin
        sendIn(0, 1, pat(20));
        it.vc = 2'd1; it.data = pat(20); it.due = cycle + 1; expQ[2].push_back(it);
      end
      #5;
      chk(coreInValid == 0, "R2 core input quiet while gated", FW'(coreInValid), 0);
      if (i > 0) chk(latchEmpty == 1'b0, "R3 latch holding", FW'(latchEmpty), 0);
      if (i == 1) chk(linkOutValid[2] && eLinkOutValid[2] == 1'b0, "R7 edge drops vertical flit",
                      FW'(eLinkOutValid[2]), 0);
      cyc();
    end
    #5 chk(latchEmpty == 1'b0, "R3 last flit held", FW'(latchEmpty), 0);
    cyc();
    #5 chk(latchEmpty == 1'b1, "R3 drained", FW'(latchEmpty), 1);
    chkCred(1'b1, "R8 counter while gated");
    cyc();

    // Far neighbour frees vc0 and vc1
    for (int v = 0; v < 2; v++) begin
      credInValid[1] = 1'b1; credInVc[1] = VCW'(v); farOcc[v]--;
      #5 chk(credOutValid[3] && credOutVc[3] == VCW'(v) && eCredOutValid[3], "R4 gated credit relay",
             FW'(credOutVc[3]), FW'(v));
      chk(eCredOutValid[2] == 1'b0, "R7 edge relays nothing vertical", FW'(eCredOutValid[2]), 0);
      cyc();
    end
    #5 chkCred(1'b1, "R8 counter after relays");
    cyc();

    // Wake
    bypassSel = 1'b0;
    #5;
    chk(upFullValid == 4'hF, "R6 full strobe on all ports", FW'(upFullValid), 4'hF);
    chk(eUpFullValid == 4'b1010, "R7 edge full ports", FW'(eUpFullValid), 4'b1010);
    chk(latchEmpty == 1'b1, "R3 empty at wake", FW'(latchEmpty), 1);
    chkCred(1'b0, "R8 counter after wake");
    cyc();
    #5 chk(upFullValid == 0, "R6 full pulse ends", FW'(upFullValid), 0);
    cyc();
    sendIn(3, 0, pat(30)); upCnt[0]--; coreOcc[0]++;
    #5 chk(coreInValid[3] && coreInData[3] == pat(30), "R1 core path after wake", coreInData[3], pat(30));
    cyc();
    repeat (3) cyc();
    for (int p = 0; p < 4; p++)
      chk(expQ[p].size() == 0, "R2 all expected flits seen", FW'(expQ[p].size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule